// File: doc/BRIEF.md
# Iterative Integer Multiply-Divide Unit

This block is a sequential arithmetic unit that sits beside the main adder/logic ALU of a processor and handles 32-bit unsigned multiplication and division. It has no fast combinational multiplier or divider. It runs one shared shift register datapath for one bit per clock. A multiply adds the multiplicand into an accumulator when the current multiplier bit is set, then shifts right. A divide shifts the partial remainder left, does a trial subtraction of the divisor, and keeps the difference only when the subtraction does not borrow.

A request is presented on a valid/ready pair. `req_ready` is high exactly when the unit is idle, and a request is taken on a rising edge where `req_valid` and `req_ready` are both high. There is no queueing. A `req_valid` held while the unit is busy is dropped, not stalled, so the requester must watch `req_ready` and keep its request up until the request is taken. Results are never streamed out. They are written into a dedicated HI/LO register pair that holds its contents until the next operation completes. A one-cycle `done` pulse marks the update.

Top module: `mdu_top`

## Requirements
- R1: After reset, `busy` and `done` are low, `req_ready` is high, and `res_hi` and `res_lo` are zero.
- R2: A request is accepted on a rising edge where `req_valid` is high and `busy` is low. `busy` is high, and `req_ready` low, from the cycle after acceptance until the operation completes.
- R3: `req_op` selects the operation: 0 is multiply and 1 is divide. Both operands are unsigned 32-bit values.
- R4: Multiply of `opnd_a` by `opnd_b` writes the upper 32 bits of the 64-bit product to `res_hi` and the lower 32 bits to `res_lo`.
- R5: Divide of `opnd_a` by a nonzero `opnd_b` writes the quotient to `res_lo` and the remainder to `res_hi`.
- R6: Divide by zero completes normally with `res_lo` all ones and `res_hi` equal to the dividend.
- R7: A multiply has `done` high in the cycle after the 33rd rising edge, counting the accepting edge as the first. `busy` is high for 32 cycles.
- R8: A divide has `done` high in the cycle after the 35th rising edge, counting the accepting edge as the first. `busy` is high for 34 cycles.
- R9: `done` is a single-cycle pulse in the cycle `busy` falls. `res_hi` and `res_lo` change only at that edge and hold their values otherwise.
- R10: A request presented while `busy` is high is ignored. It has no effect on the running operation's result or timing, or on the HI/LO registers.
- R11: A request presented in the cycle `done` is high is accepted, so operations can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle and able to take a request |
| req_op | input | 1 | Operation: 0 multiply, 1 divide |
| opnd_a | input | 32 | Multiplicand, or dividend |
| opnd_b | input | 32 | Multiplier, or divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| res_hi | output | 32 | HI register: upper product half, or remainder |
| res_lo | output | 32 | LO register: lower product half, or quotient |

## Verification
The multiply is tried with the following operands:
- Zero and one operands, which show whether the accumulator starts cleared and whether a single add lands unshifted.
- All-ones by all-ones, which drives a carry out of every add and separates a dropped carry from a correct high half.
- A scattered bit pattern, which exposes shift-order errors.

The divide is tried with the following operands:
- A divisor of one.
- A divisor of all ones.
- A dividend smaller than the divisor.
- A zero dividend.
- A zero divisor, which follows a different path from the other cases.

Together these show whether a restore is skipped or a quotient bit is misplaced. Pseudo-random operand pairs, requests injected mid-operation and requests issued in the `done` cycle distinguish correct latency and ignore behaviour from off-by-one counting.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
  typedef enum logic {
    OP_MUL = 1'b0,
    OP_DIV = 1'b1
  } mdu_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_PAD  = 2'd2
  } mdu_state_e;
endpackage

// File: rtl/mdu_mul_step.sv
// One add-and-shift step of unsigned multiplication.
module mdu_mul_step #(
  parameter int W = 32
) (
  input  logic [W-1:0] acc,
  input  logic [W-1:0] mplr,
  input  logic [W-1:0] mcand,
  output logic [W-1:0] acc_nx,
  output logic [W-1:0] mplr_nx
);
  logic [W:0] sum;

  always_comb begin
    sum     = {1'b0, acc} + (mplr[0] ? {1'b0, mcand} : '0);
    acc_nx  = sum[W:1];
    mplr_nx = {sum[0], mplr[W-1:1]};
  end
endmodule

// File: rtl/mdu_div_step.sv
// One shift, trial-subtract and test step of restoring division.
module mdu_div_step #(
  parameter int W = 32
) (
  input  logic [W:0]   rem,
  input  logic [W-1:0] quo,
  input  logic [W-1:0] dvsr,
  output logic [W:0]   rem_nx,
  output logic [W-1:0] quo_nx
);
  logic [W:0]   shifted;
  logic [W+1:0] diff;
  logic         fits;

  always_comb begin
    shifted = {rem[W-1:0], quo[W-1]};
    diff    = {1'b0, shifted} - {2'b00, dvsr};
    fits    = ~diff[W+1];
    rem_nx  = fits ? diff[W:0] : shifted;
    quo_nx  = {quo[W-2:0], fits};
  end
endmodule

// File: rtl/mdu_ctrl.sv
// Sequencer: one step per bit, plus a fixed settle tail for divide.
module mdu_ctrl
  import mdu_pkg::*;
#(
  parameter int W       = 32,
  parameter int DIV_PAD = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic op_div,
  output logic busy,
  output logic step_en,
  output logic div_mode,
  output logic finish
);
  localparam int CW       = $clog2(W + DIV_PAD + 1);
  localparam int PAD_LAST = (DIV_PAD > 0) ? DIV_PAD - 1 : 0;
  localparam bit HAS_PAD  = (DIV_PAD > 0);

  mdu_state_e    state;
  logic [CW-1:0] cnt;
  logic          last_bit;
  logic          last_pad;

  always_comb begin
    last_bit = (state == ST_RUN) && (cnt == CW'(W - 1));
    last_pad = (state == ST_PAD) && (cnt == CW'(PAD_LAST));
    busy     = (state != ST_IDLE);
    step_en  = (state == ST_RUN);
    finish   = (last_bit && !(div_mode && HAS_PAD)) || last_pad;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      div_mode <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept) begin
            state    <= ST_RUN;
            cnt      <= '0;
            div_mode <= op_div;
          end
        end
        ST_RUN: begin
          if (last_bit) begin
            cnt   <= '0;
            state <= (div_mode && HAS_PAD) ? ST_PAD : ST_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_PAD: begin
          if (last_pad) state <= ST_IDLE;
          else          cnt   <= cnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mdu_top.sv
// Iterative unsigned multiply/divide with HI/LO result registers.
module mdu_top
  import mdu_pkg::*;
#(
  parameter int W       = 32,
  parameter int DIV_PAD = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  output logic         req_ready,
  input  logic         req_op,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] res_hi,
  output logic [W-1:0] res_lo
);
  logic         accept, step_en, div_mode, finish;
  logic [W:0]   acc, acc_d;
  logic [W-1:0] shreg, shreg_d, opb;
  logic [W-1:0] m_acc, m_sh;
  logic [W:0]   d_acc;
  logic [W-1:0] d_sh;

  assign req_ready = ~busy;
  assign accept    = req_valid & ~busy;

  mdu_ctrl #(.W(W), .DIV_PAD(DIV_PAD)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .op_div   (req_op == OP_DIV),
    .busy     (busy),
    .step_en  (step_en),
    .div_mode (div_mode),
    .finish   (finish)
  );

  mdu_mul_step #(.W(W)) u_mul (
    .acc     (acc[W-1:0]),
    .mplr    (shreg),
    .mcand   (opb),
    .acc_nx  (m_acc),
    .mplr_nx (m_sh)
  );

  mdu_div_step #(.W(W)) u_div (
    .rem    (acc),
    .quo    (shreg),
    .dvsr   (opb),
    .rem_nx (d_acc),
    .quo_nx (d_sh)
  );

  always_comb begin
    acc_d   = acc;
    shreg_d = shreg;
    if (step_en) begin
      if (div_mode) begin
        acc_d   = d_acc;
        shreg_d = d_sh;
      end else begin
        acc_d   = {1'b0, m_acc};
        shreg_d = m_sh;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc    <= '0;
      shreg  <= '0;
      opb    <= '0;
      res_hi <= '0;
      res_lo <= '0;
      done   <= 1'b0;
    end else begin
      done <= finish;
      if (accept) begin
        acc   <= '0;
        shreg <= opnd_a;
        opb   <= opnd_b;
      end else begin
        acc   <= acc_d;
        shreg <= shreg_d;
      end
      if (finish) begin
        res_hi <= acc_d[W-1:0];
        res_lo <= shreg_d;
      end
    end
  end
endmodule

// File: rtl/mdu_chk.sv
module mdu_chk #(
  parameter int W       = 32,
  parameter int DIV_PAD = 2
) (
  input logic         clk,
  input logic         rst_n,
  input logic         req_valid,
  input logic         req_op,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] res_hi,
  input logic [W-1:0] res_lo
);
  localparam int BW = $clog2(W + DIV_PAD + 2) + 1;
  logic [BW-1:0] busy_cycles;
  logic          op_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_cycles <= '0;
      op_seen     <= 1'b0;
    end else begin
      busy_cycles <= busy ? busy_cycles + 1'b1 : '0;
      if (req_valid && !busy) op_seen <= req_op;
    end
  end

  a_r2_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !busy |=> busy);
  a_r9_done_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r9_hold_results: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(res_hi) && $stable(res_lo));
  a_r10_ignore_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy && req_valid |=> busy || done);
  // R7 and R8: busy length per operation
  a_r7_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy_cycles == (op_seen ? BW'(W + DIV_PAD) : BW'(W)));
endmodule

bind mdu_top mdu_chk #(.W(W), .DIV_PAD(DIV_PAD)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_op    (req_op),
  .busy      (busy),
  .done      (done),
  .res_hi    (res_hi),
  .res_lo    (res_lo)
);

// File: tb/mdu_top_test.sv
`timescale 1ns/1ps
module mdu_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_op = 1'b0;
  logic [31:0] opnd_a = '0;
  logic [31:0] opnd_b = '0;
  logic        req_ready, busy, done;
  logic [31:0] res_hi, res_lo;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  mdu_top uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .opnd_a(opnd_a), .opnd_b(opnd_b), .busy(busy),
    .done(done), .res_hi(res_hi), .res_lo(res_lo)
  );

  // behavioural reference model
  bit          m_busy, m_done;
  int          m_left;
  logic [31:0] m_hi, m_lo, p_hi, p_lo;
  string       m_tag = "R1";
  string       p_tag;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_left = 0; m_hi = '0; m_lo = '0; m_tag = "R1";
    end else begin
      m_done = 0;
      if (m_busy) begin
        m_left--;
        if (m_left == 0) begin
          m_busy = 0; m_done = 1; m_hi = p_hi; m_lo = p_lo; m_tag = p_tag;
        end
      end else if (req_valid) begin
        logic [63:0] prod;
        m_busy = 1;
        if (req_op == 1'b0) begin
          m_left = 32;
          prod = {32'b0, opnd_a} * {32'b0, opnd_b};
          p_hi = prod[63:32]; p_lo = prod[31:0]; p_tag = "R4";
        end else begin
          m_left = 34;
          if (opnd_b == 0) begin
            p_hi = opnd_a; p_lo = 32'hFFFF_FFFF; p_tag = "R6";
          end else begin
            p_hi = opnd_a % opnd_b; p_lo = opnd_a / opnd_b; p_tag = "R5";
          end
        end
      end
    end
  end

  task automatic check(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(busy == m_busy, "R2", "busy", 64'(busy), 64'(m_busy));
      check(req_ready == !m_busy, "R2", "req_ready", 64'(req_ready), 64'(!m_busy));
      check(done == m_done, "R9", "done", 64'(done), 64'(m_done));
      check(res_hi == m_hi, m_tag, "res_hi", 64'(res_hi), 64'(m_hi));
      check(res_lo == m_lo, m_tag, "res_lo", 64'(res_lo), 64'(m_lo));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !finished) begin
      finished = 1;
      fails++; checks++;
      $display("FAIL R9 watchdog: done actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  // Called at a negedge; returns at the negedge where done is high.
  task automatic run_op(logic op, logic [31:0] a, logic [31:0] b, bit inject);
    int n;
    int exp_n;
    req_valid = 1; req_op = op; opnd_a = a; opnd_b = b;
    @(posedge clk); @(negedge clk);
    req_valid = 0;
    n = 1;
    while (!done) begin
      if (inject && n == 5) begin
        req_valid = 1; req_op = ~op; opnd_a = 32'h0BAD_F00D; opnd_b = 32'h3;
      end else begin
        req_valid = 0;
      end
      @(negedge clk);
      n++;
    end
    req_valid = 0;
    exp_n = op ? 35 : 33;
    if (op) check(n == exp_n, "R8", "divide latency", 64'(n), 64'(exp_n));
    else    check(n == exp_n, "R7", "multiply latency", 64'(n), 64'(exp_n));
  endtask

  initial begin
    logic [31:0] lfsr;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(busy == 0 && done == 0 && req_ready == 1, "R1", "ctrl after reset",
          64'({busy, done, req_ready}), 64'(3'b001));
    check(res_hi == 0 && res_lo == 0, "R1", "hi/lo after reset",
          {res_hi, res_lo}, 64'(0));
    rst_n = 1;
    @(negedge clk);
    // R3/R4: multiply patterns
    run_op(1'b0, 32'd0, 32'h1234_5678, 0);
    @(negedge clk);
    run_op(1'b0, 32'h89AB_CDEF, 32'd1, 0);
    run_op(1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0);  // R11 back to back
    check(res_hi == 32'hFFFF_FFFE && res_lo == 32'h1, "R4", "all-ones product",
          {res_hi, res_lo}, 64'hFFFF_FFFE_0000_0001);
    run_op(1'b0, 32'h1234_5678, 32'h9ABC_DEF0, 0);
    // R5: divide patterns
    run_op(1'b1, 32'd100, 32'd7, 0);
    check(res_lo == 14 && res_hi == 2, "R5", "100/7",
          {res_hi, res_lo}, {32'd2, 32'd14});
    run_op(1'b1, 32'hDEAD_BEEF, 32'd1, 0);
    run_op(1'b1, 32'hFFFF_FFFE, 32'hFFFF_FFFF, 0);
    run_op(1'b1, 32'd0, 32'd5, 0);
    // R6: divide by zero
    run_op(1'b1, 32'hCAFE_0123, 32'd0, 0);
    check(res_lo == 32'hFFFF_FFFF && res_hi == 32'hCAFE_0123, "R6", "x/0",
          {res_hi, res_lo}, 64'hCAFE_0123_FFFF_FFFF);
    // R10: requests while busy are dropped
    repeat (2) @(negedge clk);
    run_op(1'b0, 32'd6, 32'd7, 1);
    check(res_lo == 42 && res_hi == 0, "R10", "result after ignored request",
          {res_hi, res_lo}, 64'd42);
    repeat (3) @(negedge clk);
    check(busy == 0, "R10", "idle after ignored request", 64'(busy), 64'(0));
    run_op(1'b1, 32'd1000, 32'd9, 1);
    // pseudo-random mix, back to back (R11)
    lfsr = 32'hACE1_2468;
    for (int i = 0; i < 16; i++) begin
      logic [31:0] a, b;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      a = lfsr * 32'h9E37_79B9;
      b = (i % 5 == 4) ? 32'd0 : (lfsr >> (i % 24));
      run_op(i[0], a, b, 0);
    end
    repeat (2) @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule